// File: doc/BRIEF.md
# Parallel Converter Read Sequencer

This block is the host-side controller for an external parallel-output analog-to-digital converter. A one-cycle sample request from the system starts a sequence. The controller drives the active-low conversion-start strobe for a set number of host cycles. It then watches the converter's conversion-in-progress flag and waits for that flag to fall. After the fall it pulls chip-select and read low together for a set number of cycles. On the last of those cycles it captures the parallel data word. It then returns the word with a one-cycle valid strobe.

Two modes are available, chosen per sample by `lowpwr_i`. In fast mode the start strobe returns high as soon as the minimum pulse width has passed, which is well before the conversion ends. In power-saving mode the strobe is kept low past the end of conversion, which makes the converter go to sleep. The strobe stays low while the controller is idle. When the next request arrives, the controller first raises the strobe to wake the converter and waits the wake-up time before it starts the new conversion. A watchdog counter ends a conversion that never completes and reports it as a timeout.

Top module: `adc_rd_ctrl`

## Requirements
- R1: During and right after synchronous reset, `conv_n_o`, `cs_n_o` and `rd_n_o` are 1 (inactive), and `valid_o`, `timeout_o` and `data_o` are 0.
- R2: Every start pulse keeps `conv_n_o` low for at least PULSE_CYC cycles. In fast mode (`lowpwr_i`=0) it stays low for exactly PULSE_CYC cycles, so it is already high when `busy_i` falls.
- R3: A conversion counts as finished when the synchronised `busy_i` goes from 1 to 0. `cs_n_o` and `rd_n_o` then fall together and stay low for exactly ACCESS_CYC cycles. `data_i` is sampled on the last of those cycles.
- R4: `valid_o` is high for one cycle, on the same clock edge on which `cs_n_o` and `rd_n_o` rise. `data_o` carries the sampled word and keeps it until the next capture.
- R5: In power-saving mode (`lowpwr_i`=1) `conv_n_o` stays low through the fall of `busy_i`, through the read, and through the idle time that follows.
- R6: After a power-saving conversion, the next accepted request first raises `conv_n_o`. The strobe stays high for exactly WAKE_CYC cycles before its next falling edge.
- R7: The wake-up wait of R6 also applies when the request that follows a sleep is in fast mode. The mode is sampled when each start pulse begins.
- R8: If `busy_i` has not fallen within TIMEOUT_CYC cycles of the start pulse's falling edge, `timeout_o` pulses for one cycle, `conv_n_o` goes high, no read or `valid_o` happens, and the controller goes back to idle. In cycle terms, `timeout_o` is high exactly TIMEOUT_CYC cycles after the first cycle in which `conv_n_o` is low.
- R9: Requests are accepted only in idle. A request that arrives during a sample is held and served afterwards. Several requests during one sample merge into one extra sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Sample request, one-cycle pulse |
| lowpwr_i | input | 1 | 1 selects power-saving mode for the next start pulse |
| busy_i | input | 1 | Conversion-in-progress flag from the converter (asynchronous) |
| data_i | input | DATA_W | Parallel result bus from the converter |
| conv_n_o | output | 1 | Active-low conversion-start strobe |
| cs_n_o | output | 1 | Active-low chip select |
| rd_n_o | output | 1 | Active-low read |
| data_o | output | DATA_W | Captured conversion result |
| valid_o | output | 1 | One-cycle strobe marking a new `data_o` |
| timeout_o | output | 1 | One-cycle strobe: conversion did not complete in time |

## Verification
The assertions assume that `busy_i` rises only after a start pulse has fallen, and that a conversion lasts longer than the start pulse plus the synchroniser delay. Under that assumption, a fall of the flag never arrives while the pulse is still being timed. The bench's converter model raises its flag on the strobe's falling edge and holds it high for 20 cycles, which is longer than the 3-cycle pulse. The model drives the bus only while both select and read are low. A separate "dead" setting never raises the flag, so that the timeout path can be exercised on its own.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAKE,
    ST_START,
    ST_CONV,
    ST_READ
  } ctrl_st_e;
endpackage

// File: rtl/adc_rd_sync.sv
module adc_rd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/adc_rd_pend.sv
module adc_rd_pend (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic pend
);
  // a request in the same cycle as a clear is a new one and survives
  always_ff @(posedge clk) begin
    if (rst) pend <= 1'b0;
    else     pend <= set | (pend & ~clr);
  end
endmodule

// File: rtl/adc_rd_timer.sv
module adc_rd_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         done
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
  import adc_rd_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int PULSE_CYC   = 3,
  parameter int ACCESS_CYC  = 2,
  parameter int WAKE_CYC    = 200,
  parameter int TIMEOUT_CYC = 100,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_i,
  input  logic              lowpwr_i,
  input  logic              busy_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              conv_n_o,
  output logic              cs_n_o,
  output logic              rd_n_o,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              timeout_o
);
  localparam int PH_A   = (PULSE_CYC > ACCESS_CYC) ? PULSE_CYC : ACCESS_CYC;
  localparam int PH_MAX = (WAKE_CYC > PH_A) ? WAKE_CYC : PH_A;
  localparam int TW     = $clog2(PH_MAX + 1);
  localparam int TOW    = $clog2(TIMEOUT_CYC + 1);

  ctrl_st_e st;
  logic     busy_s, busy_d, pend, asleep, lp_q;
  logic     ph_done, tmo_done;
  logic     accept, go_wake, go_start, go_read, fall, ph_load;
  logic [TW-1:0] ph_val;

  adc_rd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(busy_i), .q(busy_s)
  );

  adc_rd_pend u_pend (
    .clk(clk), .rst(rst), .set(req_i), .clr(accept), .pend(pend)
  );

  always_ff @(posedge clk) begin
    if (rst) busy_d <= 1'b0;
    else     busy_d <= busy_s;
  end

  always_comb begin
    accept   = (st == ST_IDLE) && pend;
    go_wake  = accept && asleep;
    go_start = (accept && !asleep) || ((st == ST_WAKE) && ph_done);
    fall     = busy_d && !busy_s;
    go_read  = (st == ST_CONV) && fall;
    ph_load  = go_wake || go_start || go_read;
    if (go_wake)      ph_val = TW'(WAKE_CYC - 1);
    else if (go_read) ph_val = TW'(ACCESS_CYC - 1);
    else              ph_val = TW'(PULSE_CYC - 1);
  end

  adc_rd_timer #(.W(TW)) u_phase (
    .clk(clk), .rst(rst), .load(ph_load), .val(ph_val), .done(ph_done)
  );

  adc_rd_timer #(.W(TOW)) u_tmo (
    .clk(clk), .rst(rst), .load(go_start), .val(TOW'(TIMEOUT_CYC - 1)),
    .done(tmo_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      conv_n_o  <= 1'b1;
      cs_n_o    <= 1'b1;
      rd_n_o    <= 1'b1;
      data_o    <= '0;
      valid_o   <= 1'b0;
      timeout_o <= 1'b0;
      asleep    <= 1'b0;
      lp_q      <= 1'b0;
    end else begin
      valid_o   <= 1'b0;
      timeout_o <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (go_wake) begin
            st       <= ST_WAKE;
            conv_n_o <= 1'b1;
          end else if (go_start) begin
            st       <= ST_START;
            conv_n_o <= 1'b0;
            lp_q     <= lowpwr_i;
          end
        end
        ST_WAKE: begin
          if (ph_done) begin
            st       <= ST_START;
            conv_n_o <= 1'b0;
            asleep   <= 1'b0;
            lp_q     <= lowpwr_i;
          end
        end
        ST_START: begin
          if (ph_done) begin
            st <= ST_CONV;
            if (!lp_q) conv_n_o <= 1'b1;
          end
        end
        ST_CONV: begin
          if (fall) begin
            st     <= ST_READ;
            cs_n_o <= 1'b0;
            rd_n_o <= 1'b0;
            if (lp_q) asleep <= 1'b1;
          end else if (tmo_done) begin
            st        <= ST_IDLE;
            conv_n_o  <= 1'b1;
            timeout_o <= 1'b1;
          end
        end
        ST_READ: begin
          if (ph_done) begin
            st      <= ST_IDLE;
            cs_n_o  <= 1'b1;
            rd_n_o  <= 1'b1;
            data_o  <= data_i;
            valid_o <= 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_rd_chk.sv
module adc_rd_chk #(
  parameter int PULSE_CYC  = 3,
  parameter int ACCESS_CYC = 2
) (
  input logic clk,
  input logic rst,
  input logic conv_n,
  input logic cs_n,
  input logic rd_n,
  input logic valid,
  input logic tmo
);
  logic [31:0] low_cnt, cs_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt <= '0;
      cs_cnt  <= '0;
    end else begin
      low_cnt <= conv_n ? '0 : low_cnt + 1;
      cs_cnt  <= cs_n   ? '0 : cs_cnt + 1;
    end
  end

  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (conv_n && cs_n && rd_n && !valid && !tmo));

  a_r2_min_pulse: assert property (@(posedge clk) disable iff (rst)
    $rose(conv_n) |-> (low_cnt >= 32'(PULSE_CYC)));

  a_r3_access_width: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |-> (cs_cnt == 32'(ACCESS_CYC)));

  a_r4_valid_on_release: assert property (@(posedge clk) disable iff (rst)
    valid |-> ($rose(cs_n) && $rose(rd_n)));

  a_r8_timeout_clean: assert property (@(posedge clk) disable iff (rst)
    tmo |-> (conv_n && cs_n && !valid));

  a_r9_no_start_in_read: assert property (@(posedge clk) disable iff (rst)
    !cs_n |-> !$fell(conv_n));
endmodule

bind adc_rd_ctrl adc_rd_chk #(
  .PULSE_CYC(PULSE_CYC),
  .ACCESS_CYC(ACCESS_CYC)
) u_chk (
  .clk(clk), .rst(rst), .conv_n(conv_n_o), .cs_n(cs_n_o), .rd_n(rd_n_o),
  .valid(valid_o), .tmo(timeout_o)
);

// File: tb/tb_adc_rd_ctrl.sv
module tb_adc_rd_ctrl;
  localparam int DW = 12, PC = 3, AC = 2, WC = 200, TC = 100, CONV_CYC = 20;

  logic clk = 1'b0, rst = 1'b1, req_i = 1'b0, lowpwr_i = 1'b0, busy_i = 1'b0;
  logic [DW-1:0] word = '0, data_i, data_o;
  logic conv_n_o, cs_n_o, rd_n_o, valid_o, timeout_o;

  int nchk = 0, nerr = 0, valids = 0, timeouts = 0;
  bit dead = 0, exp_lp = 0, done_flag = 0;
  logic [DW-1:0] exp_q[$];
  logic [DW-1:0] last_data = '0;

  always #2.5 clk = ~clk;

  assign data_i = (!cs_n_o && !rd_n_o) ? word : '0;

  adc_rd_ctrl #(.DATA_W(DW), .PULSE_CYC(PC), .ACCESS_CYC(AC), .WAKE_CYC(WC),
                .TIMEOUT_CYC(TC), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst), .req_i(req_i), .lowpwr_i(lowpwr_i), .busy_i(busy_i),
    .data_i(data_i), .conv_n_o(conv_n_o), .cs_n_o(cs_n_o), .rd_n_o(rd_n_o),
    .data_o(data_o), .valid_o(valid_o), .timeout_o(timeout_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // converter model and monitor (scoreboard pop side)
  initial begin
    bit prev_conv = 1, prev_cs = 1, sleeping = 0, waking = 0;
    int conv_left = 0, lo_cnt = 0, hi_cnt = 0, cs_cnt = 0, tlow = 0;
    logic [DW-1:0] next_word = 12'hFFF;
    forever begin
      @(negedge clk);
      if (rst) begin
        busy_i = 0; prev_conv = 1; prev_cs = 1; sleeping = 0; waking = 0;
        lo_cnt = 0; hi_cnt = 0; cs_cnt = 0;
        continue;
      end
      tlow++;
      if (prev_conv && !conv_n_o) begin
        if (waking) begin
          if (exp_lp) chk(hi_cnt == WC, "R6 wake high width", hi_cnt, WC);
          else        chk(hi_cnt == WC, "R7 wake before fast start", hi_cnt, WC);
          waking = 0;
        end
        if (!dead && !busy_i) begin busy_i = 1; conv_left = CONV_CYC; end
        tlow = 0;
      end
      if (!prev_conv && conv_n_o) begin
        if (sleeping) begin waking = 1; sleeping = 0; end
        else if (!exp_lp) chk(lo_cnt == PC, "R2 fast pulse width", lo_cnt, PC);
      end
      if (conv_n_o) begin hi_cnt++; lo_cnt = 0; end
      else          begin lo_cnt++; hi_cnt = 0; end
      if (busy_i) begin
        conv_left--;
        if (conv_left == 0) begin
          busy_i = 0;
          word = next_word;
          exp_q.push_back(next_word);
          next_word = next_word + 12'h6B5;
          if (exp_lp) chk(conv_n_o == 0, "R5 strobe low at end", int'(conv_n_o), 0);
          else        chk(conv_n_o == 1, "R2 strobe high at end", int'(conv_n_o), 1);
          if (!conv_n_o) sleeping = 1;
        end
      end
      if (cs_n_o != rd_n_o) chk(0, "R3 select/read paired", int'(rd_n_o), int'(cs_n_o));
      if (!cs_n_o) cs_cnt++;
      else begin
        if (!prev_cs) chk(cs_cnt == AC, "R3 access width", cs_cnt, AC);
        cs_cnt = 0;
      end
      if (valid_o) begin
        valids++;
        chk(cs_n_o && !prev_cs, "R4 valid on release", int'(cs_n_o), 1);
        if (exp_q.size() == 0) chk(0, "R4 unexpected valid", int'(data_o), -1);
        else begin
          logic [DW-1:0] e;
          e = exp_q.pop_front();
          chk(data_o == e, "R4 data word", int'(data_o), int'(e));
        end
        last_data = data_o;
      end
      if (timeout_o) begin
        timeouts++;
        chk(tlow == TC, "R8 timeout latency", tlow, TC);
        chk(conv_n_o && !valid_o, "R8 strobe released", int'(conv_n_o), 1);
      end
      prev_conv = conv_n_o;
      prev_cs = cs_n_o;
    end
  end

  task automatic do_req();
    @(negedge clk) req_i = 1;
    @(negedge clk) req_i = 0;
  endtask

  task automatic wait_valids(input int target, input string tag);
    int g = 0;
    while (valids < target && g < 5000) begin @(negedge clk); g++; end
    chk(valids >= target, tag, valids, target);
  endtask

  initial begin
    int base;
    repeat (5) @(negedge clk);
    chk(conv_n_o && cs_n_o && rd_n_o && !valid_o && !timeout_o && data_o == 0,
        "R1 outputs in reset", int'(conv_n_o), 1);
    rst = 0;
    @(negedge clk);
    chk(conv_n_o && cs_n_o && rd_n_o && !valid_o && !timeout_o && data_o == 0,
        "R1 outputs after reset", int'(cs_n_o), 1);

    // fast mode samples, scoreboard compares words
    for (int i = 0; i < 4; i++) begin
      do_req();
      wait_valids(i + 1, "R3 fast sample done");
    end
    repeat (10) @(negedge clk);
    chk(data_o == last_data, "R4 data held", int'(data_o), int'(last_data));

    // R9: extra requests during a sample merge into one
    base = valids;
    do_req();
    repeat (5) @(negedge clk);
    do_req();
    do_req();
    wait_valids(base + 2, "R9 held request served");
    repeat (300) @(negedge clk);
    chk(valids == base + 2, "R9 merged requests", valids, base + 2);

    // power-saving mode
    exp_lp = 1; lowpwr_i = 1;
    do_req();
    wait_valids(base + 3, "R5 sleep sample done");
    repeat (20) @(negedge clk);
    chk(conv_n_o == 0, "R5 strobe low in idle", int'(conv_n_o), 0);
    do_req();
    wait_valids(base + 4, "R6 sample after wake");
    repeat (5) @(negedge clk);
    exp_lp = 0; lowpwr_i = 0;
    do_req();
    wait_valids(base + 5, "R7 fast sample after sleep");
    repeat (5) @(negedge clk);
    chk(conv_n_o == 1, "R7 fast idle strobe high", int'(conv_n_o), 1);

    // timeout
    base = valids;
    dead = 1;
    do_req();
    begin
      int g = 0;
      while (timeouts == 0 && g < 1000) begin @(negedge clk); g++; end
    end
    chk(timeouts == 1, "R8 timeout flagged", timeouts, 1);
    repeat (20) @(negedge clk);
    chk(valids == base, "R8 no data on timeout", valids, base);
    dead = 0;
    do_req();
    wait_valids(base + 1, "R8 recovery sample");
    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R4 scoreboard drained", exp_q.size(), 0);
    done_flag = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule